// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. Software hands it one character at a time through a write strobe. The character lands in a one-entry holding register. When the shifter is free and the peer allows it, the character moves into the shifter. The shifter sends it on the serial line: a start bit, the data bits least significant first, an optional parity bit and one or two stop bits. Because of the holding register, the next character can be written while the current one is still on the line, so consecutive frames leave with no idle gap.

Bit timing comes from an external enable that pulses at sixteen times the bit rate, and every bit lasts sixteen of those pulses. Data length, parity mode and stop-bit count are static inputs, sampled at the moment a character enters the shifter. Three status outputs are provided: a holding-empty flag, an activity flag covering both the register and the shifter, and a request-to-send output. A permission input from the peer gates the start of each frame but never cuts a frame short. A break input forces the line low for as long as it is held.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset the line `txd` is 1, `buf_empty` is 1, `busy` is 0 and `rts` is 0; the line is 1 whenever no frame is being shifted and no break is requested.
- R2: A frame is a 0 start bit, then the data bits with bit 0 first, then parity if enabled, then stop bits at 1; every bit lasts 16 pulses of `tick16`. `len_sel` selects 7 (value 0), 8 (value 1 or 3) or 9 (value 2) data bits; unused high bits of `wr_data` are ignored.
- R3: `par_sel` 1 gives even parity and 2 gives odd parity, both computed over the selected data bits only; 0 and 3 send no parity bit.
- R4: `two_stop` at 1 sends two stop bits and at 0 sends one.
- R5: `buf_empty` is 0 in the cycle after a write and returns to 1 when the held character moves into the shifter.
- R6: A character written while a frame is shifting begins its start bit exactly at the end of the previous frame's last stop bit.
- R7: A write while the holding register is full replaces the pending character; only the last value written is sent, once.
- R8: `busy` is 1 while a character is held or shifting and falls only after the last stop bit ends with the holding register empty.
- R9: While `cts` is 0 no new frame starts; a frame already in progress completes intact, and the held character is sent once `cts` returns to 1.
- R10: `rts` is 1 exactly while the holding register has a character waiting to be sent.
- R11: While `brk` is 1 the line is 0, starting one cycle after `brk` rises; one cycle after `brk` falls on an idle transmitter the line is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| len_sel | input | 2 | Data length select |
| par_sel | input | 2 | Parity mode select |
| two_stop | input | 1 | Two stop bits when 1 |
| cts | input | 1 | Peer permits new frames when 1 |
| brk | input | 1 | Hold the line low when 1 |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_MAX (9) | Character to send |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register empty |
| busy | output | 1 | Character held or shifting |
| rts | output | 1 | Character waiting to be sent |

## Verification
A wrong bit counter or shift pointer shows on `txd` within one frame as a wrong, missing or extra bit at a mid-bit sample. The bench decodes every frame sixteen ticks per bit from the start edge and compares it with a frame computed from the data and format. A wrong handoff between the holding register and the shifter shows as an idle gap between frames, a repeated or dropped character, or status flags that disagree with the line, visible at the next frame boundary. Gating faults on `cts` show as a frame starting while the peer forbids it, detected within the hold window the bench imposes.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } par_mode_e;

  typedef enum logic [1:0] {
    LEN_SHORT = 2'd0,
    LEN_BYTE  = 2'd1,
    LEN_LONG  = 2'd2,
    LEN_RSVD  = 2'd3
  } len_mode_e;

endpackage

// File: rtl/utx_hold_buf.sv
module utx_hold_buf #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          empty
);

  // A write in the same cycle as a take wins: the old value is taken
  // by the shifter and the new one stays held.
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (wr_en) begin
        data  <= wr_data;
        full  <= 1'b1;
        empty <= 1'b0;
      end else if (take) begin
        full  <= 1'b0;
        empty <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/utx_framer.sv
module utx_framer #(
  parameter int DW = 9,
  parameter int FW = DW + 4,
  parameter int LW = 4
) (
  input  logic [DW-1:0] data,
  input  logic [1:0]    len_sel,
  input  logic [1:0]    par_sel,
  input  logic          two_stop,
  output logic [FW-1:0] frame,
  output logic [LW-1:0] nbits
);
  import utx_pkg::*;

  int   ndata;
  logic par_en;
  logic par_acc;

  always_comb begin
    case (len_mode_e'(len_sel))
      LEN_SHORT: ndata = DW - 2;
      LEN_LONG:  ndata = DW;
      default:   ndata = DW - 1;
    endcase
    par_en  = (par_mode_e'(par_sel) == PAR_EVEN) || (par_mode_e'(par_sel) == PAR_ODD);
    par_acc = 1'b0;
    frame   = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < ndata) begin
        frame[i+1] = data[i];
        par_acc    = par_acc ^ data[i];
      end
    end
    if (par_en) begin
      frame[ndata+1] = (par_mode_e'(par_sel) == PAR_ODD) ? ~par_acc : par_acc;
    end
    nbits = LW'(1 + ndata + (par_en ? 1 : 0) + (two_stop ? 2 : 1));
  end

endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
  parameter int OSR = 16,
  parameter int CW  = $clog2(OSR)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic restart,
  output logic bit_end
);

  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt;

  assign bit_end = run & tick & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
  parameter int FW = 13,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pend,
  input  logic          cts,
  input  logic [FW-1:0] frame,
  input  logic [LW-1:0] nbits,
  input  logic          bit_end,
  input  logic          brk,
  output logic          sending,
  output logic          txd,
  output logic          take
);

  logic [FW-1:0] sh, sh_n;
  logic [LW-1:0] left, left_n;
  logic          send_n;
  logic          last;

  assign last = (left == LW'(1));
  // A new frame may start from idle or exactly at the end of the last bit.
  assign take = pend & cts & (~sending | (bit_end & last));

  always_comb begin
    sh_n   = sh;
    left_n = left;
    send_n = sending;
    if (take) begin
      sh_n   = frame;
      left_n = nbits;
      send_n = 1'b1;
    end else if (sending && bit_end) begin
      if (last) begin
        sh_n   = '1;
        left_n = '0;
        send_n = 1'b0;
      end else begin
        sh_n   = {1'b1, sh[FW-1:1]};
        left_n = left - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '1;
      left    <= '0;
      sending <= 1'b0;
      txd     <= 1'b1;
    end else begin
      sh      <= sh_n;
      left    <= left_n;
      sending <= send_n;
      txd     <= brk ? 1'b0 : sh_n[0];
    end
  end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_MAX = 9,
  parameter int OSR      = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick16,
  input  logic [1:0]          len_sel,
  input  logic [1:0]          par_sel,
  input  logic                two_stop,
  input  logic                cts,
  input  logic                brk,
  input  logic                wr_en,
  input  logic [DATA_MAX-1:0] wr_data,
  output logic                txd,
  output logic                buf_empty,
  output logic                busy,
  output logic                rts
);

  localparam int FW = DATA_MAX + 4;
  localparam int LW = $clog2(FW + 1);

  logic [DATA_MAX-1:0] held;
  logic                full;
  logic                take;
  logic [FW-1:0]       frame;
  logic [LW-1:0]       nbits;
  logic                bit_end;
  logic                sending;

  utx_hold_buf #(.DW(DATA_MAX)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .take(take),
    .data(held), .full(full), .empty(buf_empty)
  );

  utx_framer #(.DW(DATA_MAX), .FW(FW), .LW(LW)) u_frame (
    .data(held), .len_sel(len_sel), .par_sel(par_sel), .two_stop(two_stop),
    .frame(frame), .nbits(nbits)
  );

  utx_bit_timer #(.OSR(OSR)) u_timer (
    .clk(clk), .rst(rst), .tick(tick16), .run(sending), .restart(take),
    .bit_end(bit_end)
  );

  utx_shifter #(.FW(FW), .LW(LW)) u_shift (
    .clk(clk), .rst(rst), .pend(full), .cts(cts), .frame(frame), .nbits(nbits),
    .bit_end(bit_end), .brk(brk), .sending(sending), .txd(txd), .take(take)
  );

  assign busy = sending | full;
  assign rts  = full;

endmodule

// File: rtl/utx_tx_checker.sv
module utx_tx_checker (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic brk,
  input logic cts,
  input logic txd,
  input logic buf_empty,
  input logic busy,
  input logic sending
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    (!sending && !$past(brk)) |-> txd);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sending) |-> !txd);

  assert_empty_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> !buf_empty);

  assert_busy_pending_R8: assert property (@(posedge clk) disable iff (rst)
    !buf_empty |-> busy);

  assert_cts_gate_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sending) |-> $past(cts));

  assert_break_low_R11: assert property (@(posedge clk) disable iff (rst)
    $past(brk) |-> !txd);

endmodule

bind uart_tx_dbuf utx_tx_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .brk(brk), .cts(cts), .txd(txd),
  .buf_empty(buf_empty), .busy(busy), .sending(sending)
);

// File: tb/uart_tx_dbuf_test.sv
module uart_tx_dbuf_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] len_sel = 2'd1;
  logic [1:0] par_sel = 2'd0;
  logic       two_stop = 1'b0;
  logic       cts = 1'b1;
  logic       brk = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       txd, buf_empty, busy, rts;

  int checks = 0;
  int fails  = 0;
  int tick_no = 0;
  int tdiv = 0;

  uart_tx_dbuf uut (
    .clk(clk), .rst(rst), .tick16(tick), .len_sel(len_sel), .par_sel(par_sel),
    .two_stop(two_stop), .cts(cts), .brk(brk), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .buf_empty(buf_empty), .busy(busy), .rts(rts)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    tick <= (tdiv == 2);
  end

  always @(posedge clk) if (tick) tick_no <= tick_no + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [12:0] exp_frame(input logic [8:0] d, input logic [1:0] ls,
                                            input logic [1:0] ps, input logic st,
                                            output int len);
    logic [12:0] f = '1;
    int n = (ls == 2'd0) ? 7 : (ls == 2'd2) ? 9 : 8;
    logic p = 1'b0;
    bit pe = (ps == 2'd1) || (ps == 2'd2);
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[i+1] = d[i];
      p = p ^ d[i];
    end
    if (pe) f[n+1] = (ps == 2'd2) ? ~p : p;
    len = 1 + n + (pe ? 1 : 0) + (st ? 2 : 1);
    return f;
  endfunction

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Waits for a start edge, samples each bit at its middle, compares the frame.
  task automatic decode(input logic [12:0] ef, input int len, input string req,
                        output int t_start, output int t_last);
    logic [12:0] got = '1;
    int guard = 0;
    t_start = 0;
    t_last = 0;
    @(negedge clk);
    while (txd !== 1'b0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 20000) begin
      chk(1'b0, req, "no start bit seen", 1, 0);
    end else begin
      t_start = tick_no;
      wait_ticks(8);
      got[0] = txd;
      for (int b = 1; b < len; b++) begin
        wait_ticks(16);
        got[b] = txd;
      end
      t_last = tick_no;
      chk(got == ef, req, "frame bits", int'(got), int'(ef));
    end
  endtask

  task automatic end_of_traffic(input string req);
    wait_ticks(8);
    chk(busy == 1'b0, req, "busy after last stop", int'(busy), 0);
    chk(txd == 1'b1 && buf_empty == 1'b1, "R1", "idle line and empty flag", int'({txd, buf_empty}), 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [12:0] ef0, ef1;
    int l0, l1, ts0, tl0, ts1, tl1;
    logic [8:0] d0, d1;
    void'($urandom(32'd1357));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(buf_empty == 1'b1, "R1", "buf_empty after reset", int'(buf_empty), 1);
    chk(busy == 1'b0 && rts == 1'b0, "R1", "busy/rts after reset", int'({busy, rts}), 0);

    // R9, R7, R5, R10: hold with cts low, overwrite, then release
    cts = 1'b0; len_sel = 2'd1; par_sel = 2'd1; two_stop = 1'b0;
    write_byte(9'h0A5);
    chk(buf_empty == 1'b0, "R5", "buf_empty after write", int'(buf_empty), 0);
    chk(rts == 1'b1, "R10", "rts with held byte", int'(rts), 1);
    chk(busy == 1'b1, "R8", "busy with held byte", int'(busy), 1);
    write_byte(9'h03C);
    repeat (200) @(negedge clk);
    chk(txd == 1'b1 && buf_empty == 1'b0, "R9", "no frame while cts low", int'({txd, buf_empty}), 2);
    cts = 1'b1;
    ef0 = exp_frame(9'h03C, 2'd1, 2'd1, 1'b0, l0);
    decode(ef0, l0, "R7", ts0, tl0);
    chk(buf_empty == 1'b1 && rts == 1'b0, "R10", "rts after handoff", int'({buf_empty, rts}), 2);
    end_of_traffic("R8");
    repeat (100) @(negedge clk);
    chk(txd == 1'b1, "R7", "overwritten byte not sent", int'(txd), 1);

    // Directed corners: 9-bit odd parity two stops, 7-bit even parity
    len_sel = 2'd2; par_sel = 2'd2; two_stop = 1'b1;
    write_byte(9'h1FF);
    ef0 = exp_frame(9'h1FF, 2'd2, 2'd2, 1'b1, l0);
    decode(ef0, l0, "R3", ts0, tl0);
    end_of_traffic("R4");
    len_sel = 2'd0; par_sel = 2'd1; two_stop = 1'b0;
    write_byte(9'h1C1);
    ef0 = exp_frame(9'h1C1, 2'd0, 2'd1, 1'b0, l0);
    decode(ef0, l0, "R2", ts0, tl0);
    end_of_traffic("R8");

    // Random formats, back-to-back pairs (R2, R3, R4, R6)
    for (int it = 0; it < 24; it++) begin
      len_sel  = 2'($urandom_range(0, 3));
      par_sel  = 2'($urandom_range(0, 3));
      two_stop = 1'($urandom_range(0, 1));
      d0 = 9'($urandom);
      d1 = 9'($urandom);
      ef0 = exp_frame(d0, len_sel, par_sel, two_stop, l0);
      ef1 = exp_frame(d1, len_sel, par_sel, two_stop, l1);
      fork
        begin
          decode(ef0, l0, "R2", ts0, tl0);
          decode(ef1, l1, "R3", ts1, tl1);
        end
        begin
          write_byte(d0);
          while (buf_empty != 1'b1) @(negedge clk);
          write_byte(d1);
        end
      join
      chk(ts1 - tl0 == 8, "R6", "gap between frames in ticks", ts1 - tl0, 8);
      end_of_traffic("R8");
    end

    // R9: cts drops mid-frame; frame completes, next one waits
    len_sel = 2'd1; par_sel = 2'd0; two_stop = 1'b0;
    ef0 = exp_frame(9'h055, 2'd1, 2'd0, 1'b0, l0);
    ef1 = exp_frame(9'h0C3, 2'd1, 2'd0, 1'b0, l1);
    fork
      decode(ef0, l0, "R9", ts0, tl0);
      begin
        write_byte(9'h055);
        while (buf_empty != 1'b1) @(negedge clk);
        write_byte(9'h0C3);
        wait_ticks(40);
        cts = 1'b0;
      end
    join
    wait_ticks(8);
    repeat (200) @(negedge clk);
    chk(txd == 1'b1, "R9", "line idle while cts low", int'(txd), 1);
    chk(rts == 1'b1 && busy == 1'b1, "R10", "rts/busy while held", int'({rts, busy}), 3);
    cts = 1'b1;
    decode(ef1, l1, "R9", ts1, tl1);
    end_of_traffic("R8");

    // R11: break on an idle line
    @(negedge clk);
    brk = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R11", "line low one cycle after break", int'(txd), 0);
    begin
      int highs = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (txd) highs++;
      end
      chk(highs == 0, "R11", "high samples during break", highs, 0);
    end
    brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R11", "line high after break release", int'(txd), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule